// File: doc/BRIEF.md
# Sprite and Palette Memory Data Port

This block is the processor-facing access logic for two small memories inside a video controller: a sprite attribute store and a colour palette store. Each memory is reached through three operations: load an address, write a data byte, read a data byte. Each memory keeps its own address counter, and that counter advances by one after every data access. Software can therefore stream a run of bytes after a single address load.

Both memories hold 16-bit words, but the processor supplies bytes. For the 512-byte lower sprite table and for the palette, a byte written to an even address is held in a latch and goes nowhere else. The following odd-address write stores the latched byte and the new byte into the word together, so the renderer never sees a half-updated entry. The 32-byte upper sprite table takes each byte directly and leaves the latch alone. Palette entries are 15-bit colours, so bit 7 of every odd palette byte is forced to zero. Reads come back on a registered output one cycle after the request, and they never disturb a latch.

Top module: `sprite_pal_port`

## Requirements
- R1: The sprite address is 10 bits. Loading it with `spr_addr_we_i` sets it to `spr_addr_i`. Each sprite data write or read advances it by one, and 0x3FF is followed by 0x000.
- R2: The palette address is 9 bits. Loading it with `pal_addr_we_i` sets it to `pal_addr_i`. Each palette data write or read advances it by one, and 0x1FF is followed by 0x000.
- R3: A sprite write to an even address below 0x200 only fills the sprite latch. The stored bytes at that address are left unchanged.
- R4: A sprite write to an odd address A below 0x200 stores the sprite latch at A with bit 0 cleared, and stores the written byte at A.
- R5: A sprite write at an address of 0x200 or above stores the byte in the upper table entry selected by address bits [4:0]. The sprite latch is not changed.
- R6: A sprite read returns, on `spr_rdata_o` in the cycle after the request, the byte at the current address. For addresses of 0x200 and above this is the upper-table entry selected by bits [4:0]. The read does not change the latch.
- R7: A palette write to an even address only fills the palette latch. A write to an odd address A stores the latch at A with bit 0 cleared, and stores the written byte AND 0x7F at A.
- R8: A palette read returns, on `pal_rdata_o` in the cycle after the request, the byte at the current address. For odd addresses bit 7 is always 0.
- R9: Reset sets both addresses, both latches and both read outputs to zero.
- R10: Loading an address keeps the latch contents. A pair may be split by an address load and is still completed by the next odd write.
- R11: When an address load coincides with a data access, the access uses the old address and the counter takes the loaded value. When a read and a write coincide, the read returns the contents from before the write and the counter advances by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| spr_addr_we_i | input | 1 | Load sprite address |
| spr_addr_i | input | 10 | Sprite address value |
| spr_wr_i | input | 1 | Sprite data write strobe |
| spr_wdata_i | input | 8 | Sprite write byte |
| spr_rd_i | input | 1 | Sprite data read strobe |
| spr_rdata_o | output | 8 | Sprite read byte, registered |
| pal_addr_we_i | input | 1 | Load palette address |
| pal_addr_i | input | 9 | Palette address value |
| pal_wr_i | input | 1 | Palette data write strobe |
| pal_wdata_i | input | 8 | Palette write byte |
| pal_rd_i | input | 1 | Palette data read strobe |
| pal_rdata_o | output | 8 | Palette read byte, registered |

## Verification
Within one channel, an address load, a data write and a data read can all arrive in the same cycle. The order in which they take effect decides both the byte that is returned and the value the counter ends on. The bench provokes these collisions with directed cycles that pair a load with a write, and a read with a write, on the upper sprite table. The random phase then raises each strobe independently, so all combinations occur. A reference model applies the read before the write and the load after both. Every returned byte is compared against the model, so a wrong ordering shows up either in the colliding read or in a later read that lands at a shifted address.

// File: rtl/spp_pkg.sv
package spp_pkg;
  localparam int unsigned SPR_AW = 10;
  localparam int unsigned PAL_AW = 9;
  localparam int unsigned HI_AW  = 5;
  typedef logic [7:0] byte_t;
endpackage

// File: rtl/spp_addr_ctr.sv
module spp_addr_ctr #(
  parameter int unsigned AW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          set_i,
  input  logic [AW-1:0] set_val_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (set_i)  addr_q <= set_val_i;
    else if (step_i) addr_q <= addr_q + AW'(1);
  end

  assign addr_o = addr_q;

  a_r1_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !set_i |=> addr_o == AW'($past(addr_o) + AW'(1)));
  a_r11_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> addr_o == $past(set_val_i));
endmodule

// File: rtl/spp_pair_mem.sv
module spp_pair_mem #(
  parameter int unsigned AW      = 9,
  parameter logic [7:0]  HI_MASK = 8'hFF,
  localparam int unsigned WORDS  = 2 ** (AW - 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o,
  output logic [7:0]    latch_o
);
  logic [7:0]  latch_q;
  logic [15:0] mem_q [WORDS];
  logic [AW-2:0] widx;

  assign widx = addr_i[AW-1:1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                latch_q <= '0;
    else if (wr_i && !addr_i[0]) latch_q <= wdata_i;
  end

  // odd write commits the whole word
  always_ff @(posedge clk_i) begin
    if (wr_i && addr_i[0]) mem_q[widx] <= {wdata_i & HI_MASK, latch_q};
  end

  always_comb begin
    if (addr_i[0]) rdata_o = mem_q[widx][15:8] & HI_MASK;
    else           rdata_o = mem_q[widx][7:0];
  end

  assign latch_o = latch_q;

  a_r4_r7_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i[0] |=>
      mem_q[$past(widx)] == {$past(wdata_i) & HI_MASK, $past(latch_q)});
  a_r3_r7_even_no_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !addr_i[0] |=> mem_q[$past(widx)] == $past(mem_q[widx]));
endmodule

// File: rtl/spp_hi_table.sv
module spp_hi_table #(
  parameter int unsigned AW = 5,
  localparam int unsigned DEPTH = 2 ** AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];

  a_r5_direct: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> mem_q[$past(addr_i)] == $past(wdata_i));
endmodule

// File: rtl/sprite_pal_port.sv
module sprite_pal_port
  import spp_pkg::*;
#(
  parameter int unsigned S_AW = SPR_AW,
  parameter int unsigned P_AW = PAL_AW,
  parameter int unsigned H_AW = HI_AW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            spr_addr_we_i,
  input  logic [S_AW-1:0] spr_addr_i,
  input  logic            spr_wr_i,
  input  logic [7:0]      spr_wdata_i,
  input  logic            spr_rd_i,
  output logic [7:0]      spr_rdata_o,
  input  logic            pal_addr_we_i,
  input  logic [P_AW-1:0] pal_addr_i,
  input  logic            pal_wr_i,
  input  logic [7:0]      pal_wdata_i,
  input  logic            pal_rd_i,
  output logic [7:0]      pal_rdata_o
);
  localparam int unsigned LO_AW = S_AW - 1;

  logic [S_AW-1:0] spr_addr;
  logic [P_AW-1:0] pal_addr;
  logic            spr_hi_sel;
  byte_t           spr_lo_rd, spr_hi_rd, pal_rd, spr_latch, pal_latch;
  byte_t           spr_rdata_q, pal_rdata_q;

  spp_addr_ctr #(.AW(S_AW)) u_spr_ctr (
    .clk_i, .rst_ni, .set_i(spr_addr_we_i), .set_val_i(spr_addr_i),
    .step_i(spr_wr_i | spr_rd_i), .addr_o(spr_addr));

  spp_addr_ctr #(.AW(P_AW)) u_pal_ctr (
    .clk_i, .rst_ni, .set_i(pal_addr_we_i), .set_val_i(pal_addr_i),
    .step_i(pal_wr_i | pal_rd_i), .addr_o(pal_addr));

  assign spr_hi_sel = spr_addr[S_AW-1];

  spp_pair_mem #(.AW(LO_AW), .HI_MASK(8'hFF)) u_spr_lo (
    .clk_i, .rst_ni, .wr_i(spr_wr_i & ~spr_hi_sel), .addr_i(spr_addr[LO_AW-1:0]),
    .wdata_i(spr_wdata_i), .rdata_o(spr_lo_rd), .latch_o(spr_latch));

  spp_hi_table #(.AW(H_AW)) u_spr_hi (
    .clk_i, .rst_ni, .wr_i(spr_wr_i & spr_hi_sel), .addr_i(spr_addr[H_AW-1:0]),
    .wdata_i(spr_wdata_i), .rdata_o(spr_hi_rd));

  spp_pair_mem #(.AW(P_AW), .HI_MASK(8'h7F)) u_pal (
    .clk_i, .rst_ni, .wr_i(pal_wr_i), .addr_i(pal_addr),
    .wdata_i(pal_wdata_i), .rdata_o(pal_rd), .latch_o(pal_latch));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      spr_rdata_q <= '0;
      pal_rdata_q <= '0;
    end else begin
      if (spr_rd_i) spr_rdata_q <= spr_hi_sel ? spr_hi_rd : spr_lo_rd;
      if (pal_rd_i) pal_rdata_q <= pal_rd;
    end
  end

  assign spr_rdata_o = spr_rdata_q;
  assign pal_rdata_o = pal_rdata_q;

  a_r5_latch_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spr_wr_i && spr_hi_sel |=> spr_latch == $past(spr_latch));
  a_r6_read_no_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spr_rd_i && !spr_wr_i |=> spr_latch == $past(spr_latch));
  a_r8_odd_top_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pal_rd_i && pal_addr[0] |=> !pal_rdata_o[7]);
  a_r10_load_keeps_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pal_addr_we_i && !pal_wr_i |=> pal_latch == $past(pal_latch));
endmodule

// File: tb/sim_sprite_pal_port.sv
module sim_sprite_pal_port;
  logic clk_i = 0, rst_ni = 0;
  logic spr_addr_we_i = 0, spr_wr_i = 0, spr_rd_i = 0;
  logic [9:0] spr_addr_i = '0;
  logic [7:0] spr_wdata_i = '0, spr_rdata_o;
  logic pal_addr_we_i = 0, pal_wr_i = 0, pal_rd_i = 0;
  logic [8:0] pal_addr_i = '0;
  logic [7:0] pal_wdata_i = '0, pal_rdata_o;

  sprite_pal_port u0 (.*);

  always #2 clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [7:0] m_lo [512]; bit k_lo [512];
  logic [7:0] m_hi [32];  bit k_hi [32];
  logic [7:0] m_pal [512]; bit k_pal [512];
  logic [7:0] m_sl = 0, m_pl = 0;
  logic [9:0] m_sa = 0;
  logic [8:0] m_pa = 0;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag,
                      input logic ss, input logic [9:0] sa, input logic sw,
                      input logic [7:0] sd, input logic sr,
                      input logic ps, input logic [8:0] pa, input logic pw,
                      input logic [7:0] pd, input logic pr);
    logic [7:0] es, ep; bit ks, kp;
    if (m_sa[9]) begin es = m_hi[m_sa[4:0]]; ks = k_hi[m_sa[4:0]]; end
    else begin es = m_lo[m_sa[8:0]]; ks = k_lo[m_sa[8:0]]; end
    ep = m_pal[m_pa]; kp = k_pal[m_pa];
    spr_addr_we_i = ss; spr_addr_i = sa; spr_wr_i = sw; spr_wdata_i = sd; spr_rd_i = sr;
    pal_addr_we_i = ps; pal_addr_i = pa; pal_wr_i = pw; pal_wdata_i = pd; pal_rd_i = pr;
    @(posedge clk_i); @(negedge clk_i);
    if (sr && ks) check({tag, " spr"}, spr_rdata_o, es);
    if (pr && kp) check({tag, " pal"}, pal_rdata_o, ep);
    if (sw) begin
      if (m_sa[9]) begin m_hi[m_sa[4:0]] = sd; k_hi[m_sa[4:0]] = 1; end
      else if (!m_sa[0]) m_sl = sd;
      else begin
        m_lo[{m_sa[8:1], 1'b0}] = m_sl; k_lo[{m_sa[8:1], 1'b0}] = 1;
        m_lo[m_sa[8:0]] = sd; k_lo[m_sa[8:0]] = 1;
      end
    end
    if (pw) begin
      if (!m_pa[0]) m_pl = pd;
      else begin
        m_pal[{m_pa[8:1], 1'b0}] = m_pl; k_pal[{m_pa[8:1], 1'b0}] = 1;
        m_pal[m_pa] = pd & 8'h7F; k_pal[m_pa] = 1;
      end
    end
    if (ss) m_sa = sa; else if (sw || sr) m_sa = m_sa + 10'd1;
    if (ps) m_pa = pa; else if (pw || pr) m_pa = m_pa + 9'd1;
    spr_addr_we_i = 0; spr_wr_i = 0; spr_rd_i = 0;
    pal_addr_we_i = 0; pal_wr_i = 0; pal_rd_i = 0;
  endtask

  // sprite-only and palette-only shorthands
  task automatic s_op(input string tag, input logic ss, input logic [9:0] sa,
                      input logic sw, input logic [7:0] sd, input logic sr);
    step(tag, ss, sa, sw, sd, sr, 0, '0, 0, '0, 0);
  endtask
  task automatic p_op(input string tag, input logic ps, input logic [8:0] pa,
                      input logic pw, input logic [7:0] pd, input logic pr);
    step(tag, 0, '0, 0, '0, 0, ps, pa, pw, pd, pr);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 512; i++) begin k_lo[i] = 0; k_pal[i] = 0; m_lo[i] = 0; m_pal[i] = 0; end
    for (int i = 0; i < 32; i++) begin k_hi[i] = 0; m_hi[i] = 0; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R9: outputs cleared, addresses and latches zero
    check("R9 rdata", spr_rdata_o, 8'h00);
    check("R9 rdata", pal_rdata_o, 8'h00);
    s_op("R9", 0, '0, 0, 8'h00, 1);          // unknown read at 0, moves to 1
    s_op("R9", 0, '0, 1, 8'hAB, 0);          // odd write commits reset latch
    s_op("R9", 1, 10'h000, 0, 0, 0);
    s_op("R9", 0, '0, 0, 0, 1);
    s_op("R9", 0, '0, 0, 0, 1);
    p_op("R9", 0, '0, 0, 0, 1);
    p_op("R9", 0, '0, 1, 8'hC5, 0);
    p_op("R9", 1, 9'h000, 0, 0, 1);
    p_op("R9", 0, '0, 0, 0, 1);
    // R3: even write leaves stored pair intact
    s_op("R3", 1, 10'h010, 1, 8'h22, 0);
    s_op("R3", 1, 10'h011, 0, 0, 0);
    s_op("R3", 0, '0, 1, 8'h33, 0);
    s_op("R3", 1, 10'h010, 0, 0, 0);
    s_op("R3", 0, '0, 1, 8'h99, 0);
    s_op("R3", 1, 10'h010, 0, 0, 0);
    s_op("R3", 0, '0, 0, 0, 1);
    s_op("R4", 0, '0, 0, 0, 1);
    // R5: upper table aliasing and latch untouched
    s_op("R5", 1, 10'h20A, 0, 0, 0);
    s_op("R5", 0, '0, 1, 8'h5C, 0);
    s_op("R5", 1, 10'h3EA, 0, 0, 0);
    s_op("R5", 0, '0, 0, 0, 1);
    s_op("R5", 1, 10'h030, 0, 0, 0);
    s_op("R5", 0, '0, 1, 8'h44, 0);
    s_op("R5", 1, 10'h205, 0, 0, 0);
    s_op("R5", 0, '0, 1, 8'h77, 0);
    s_op("R5", 1, 10'h031, 0, 0, 0);
    s_op("R5", 0, '0, 1, 8'h88, 0);
    s_op("R5", 1, 10'h030, 0, 0, 0);
    s_op("R5", 0, '0, 0, 0, 1);
    s_op("R5", 0, '0, 0, 0, 1);
    // R1: wrap 0x3FF -> 0x000
    s_op("R1", 1, 10'h3FF, 0, 0, 0);
    s_op("R1", 0, '0, 1, 8'h66, 0);
    s_op("R1", 0, '0, 0, 0, 1);
    s_op("R1", 1, 10'h3FF, 0, 0, 0);
    s_op("R1", 0, '0, 0, 0, 1);
    // R7: palette pair with bit 7 masked
    p_op("R7", 1, 9'h040, 1, 8'h12, 0);
    p_op("R7", 0, '0, 1, 8'hFF, 0);
    p_op("R7", 1, 9'h040, 0, 0, 1);
    p_op("R8", 0, '0, 0, 0, 1);
    // R2: palette wrap 0x1FF -> 0x000
    p_op("R2", 1, 9'h1FE, 1, 8'h3A, 0);
    p_op("R2", 0, '0, 1, 8'hE1, 0);
    p_op("R2", 0, '0, 0, 0, 1);
    p_op("R2", 1, 9'h1FF, 0, 0, 1);
    p_op("R2", 0, '0, 0, 0, 1);
    // R10: address load between halves keeps latch
    s_op("R10", 1, 10'h040, 1, 8'h3C, 0);
    s_op("R10", 1, 10'h041, 0, 0, 0);
    s_op("R10", 0, '0, 1, 8'h01, 0);
    s_op("R10", 1, 10'h040, 0, 0, 1);
    s_op("R10", 0, '0, 0, 0, 1);
    p_op("R10", 1, 9'h081, 0, 0, 0);
    p_op("R10", 1, 9'h080, 1, 8'h5D, 0);
    p_op("R10", 1, 9'h081, 0, 0, 0);
    p_op("R10", 0, '0, 1, 8'h02, 0);
    p_op("R10", 1, 9'h080, 0, 0, 1);
    // R11: load with write; read with write
    s_op("R11", 1, 10'h210, 0, 0, 0);
    s_op("R11", 1, 10'h211, 1, 8'hA1, 0);
    s_op("R11", 1, 10'h210, 0, 0, 0);
    s_op("R11", 0, '0, 1, 8'hB2, 1);
    s_op("R11", 0, '0, 0, 0, 1);
    s_op("R11", 1, 10'h210, 0, 0, 1);
    s_op("R11", 0, '0, 0, 0, 1);
    // random mix, both channels in parallel
    for (int i = 0; i < 6000; i++) begin
      logic ss, sw, sr, ps, pw, pr;
      logic [9:0] sa; logic [8:0] pa;
      ss = ($urandom % 8) == 0;
      sa = ($urandom % 4 == 0) ? (10'h1FC + 10'($urandom % 8)) : 10'($urandom);
      if ($urandom % 4 == 0) sa = 10'h3FC + 10'($urandom % 4);
      sw = $urandom % 2; sr = $urandom % 2;
      ps = ($urandom % 8) == 0;
      pa = ($urandom % 4 == 0) ? (9'h1FC + 9'($urandom % 4)) : 9'($urandom);
      pw = $urandom % 2; pr = $urandom % 2;
      step("R6/R8", ss, sa, sw, 8'($urandom), sr, ps, pa, pw, 8'($urandom), pr);
    end
    done = 1;
    summary();
  end
endmodule